// File: doc/BRIEF.md
# Port Access Strobe Generator

This block sits next to an 8-bit general-purpose port of a small microcontroller. It gives external logic active-low read and write strobes that follow CPU accesses to the port. A write pulse from the CPU loads the port output register at once. The write strobe follows at a fixed distance behind that load. A read pulse captures the port input pins as the value returned to the CPU. The read strobe follows three cycles later and only tells the outside world that it may now drive the next byte. Nothing is sampled when the read strobe asserts.

Strobe generation is switched by a single enable bit. Both directions have their own timing engine, so reads and writes never interfere. Each engine can hold one further request of its own kind while a sequence is running. That request is replayed as soon as the running sequence ends, which lets back-to-back accesses each get a strobe.

Top module: `port_strobe_gen`

## Requirements
- R1: A synchronous active-high reset drives `rd_n` and `wr_n` high, clears `port_out` to 0 and discards any running or queued strobe sequence.
- R2: A cycle with `cpu_wr` high loads `cpu_wdata` into `port_out` at that clock edge. A cycle with `cpu_rd` high loads `pin_in` into `cpu_rdata` at that clock edge. Both happen whether or not strobes are enabled.
- R3: If `cpu_wr` is sampled at edge E, `wr_n` is low after edges E+2 and E+3 and high again after E+4. This gives a low pulse of exactly 2 cycles.
- R4: If `cpu_rd` is sampled at edge E, `rd_n` is low after edges E+3 and E+4 and high again after E+5. This gives a low pulse of exactly 2 cycles.
- R5: While `stb_en` is 0, `rd_n` and `wr_n` stay high. Accesses sampled with `stb_en` at 0 start no strobe.
- R6: The read and write paths are independent. A read and a write in the same or nearby cycles each produce their own strobe with the timing of R3 and R4.
- R7: An access of the same kind that arrives while a sequence of that kind is running, including at its final edge, is queued. Its sequence begins at the edge where the running pulse ends, with the delay of R3/R4 counted from that edge. At most one request per direction is queued, and further requests in that window merge into it.
- R8: Dropping `stb_en` to 0 forces the strobes high in the same cycle. It also cancels the running and queued sequences, so none resumes when the enable returns.
- R9: `cpu_rdata` changes only at edges where `cpu_rd` is high. Pin changes at or after the read strobe do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Strobe timing clock; all delays count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| stb_en | input | 1 | Strobe enable control bit |
| cpu_rd | input | 1 | One-cycle CPU port read access pulse |
| cpu_wr | input | 1 | One-cycle CPU port write access pulse |
| cpu_wdata | input | 8 | Data written by the CPU |
| pin_in | input | 8 | External port input pins |
| port_out | output | 8 | Port output register |
| cpu_rdata | output | 8 | Port value returned to the CPU |
| rd_n | output | 1 | Active-low read (prefetch) strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Several properties are checked on every cycle by the assertions. A disabled engine never drives its strobe low. No low pulse runs longer than its width, and a pulse that ends with the enable still set has lasted its full width. The output register loads the written data, and the read value holds between reads. The exact start cycle of each strobe shows only in the bench's scenarios, as do queue replay after back-to-back or end-edge accesses, merging of a third request, and cancellation of pending work by the enable. The same holds for the reset clearing a queued sequence.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2
    } stb_state_e;

    typedef struct packed {
        stb_state_e state;
        cnt_t       cnt;
        logic       pend;
    } chan_t;

    localparam chan_t CHAN_IDLE = '{state: ST_IDLE, cnt: '0, pend: 1'b0};

    function automatic logic at_limit(cnt_t c, int limit);
        return c == cnt_t'(limit - 1);
    endfunction

    function automatic cnt_t bump(cnt_t c);
        return c + cnt_t'(1);
    endfunction

endpackage

// File: rtl/strobe_channel.sv
module strobe_channel
    import strobe_pkg::*;
#(
    parameter int DELAY = 2,
    parameter int WIDTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic req,
    output logic strobe_n
);

    chan_t cur;
    chan_t nxt;
    logic  wait_done;
    logic  pulse_done;

    assign wait_done  = at_limit(cur.cnt, DELAY);
    assign pulse_done = at_limit(cur.cnt, WIDTH);

    always_comb begin
        nxt = cur;
        if (!en) begin
            nxt = CHAN_IDLE;
        end else begin
            unique case (cur.state)
                ST_IDLE: begin
                    if (req) begin
                        nxt.state = ST_WAIT;
                        nxt.cnt   = '0;
                    end
                end
                ST_WAIT: begin
                    if (req) nxt.pend = 1'b1;
                    if (wait_done) begin
                        nxt.state = ST_PULSE;
                        nxt.cnt   = '0;
                    end else begin
                        nxt.cnt = bump(cur.cnt);
                    end
                end
                ST_PULSE: begin
                    if (pulse_done) begin
                        if (cur.pend || req) begin
                            nxt.state = ST_WAIT;
                            nxt.cnt   = '0;
                            nxt.pend  = cur.pend && req;
                        end else begin
                            nxt = CHAN_IDLE;
                        end
                    end else begin
                        nxt.cnt = bump(cur.cnt);
                        if (req) nxt.pend = 1'b1;
                    end
                end
                default: nxt = CHAN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= CHAN_IDLE;
        else     cur <= nxt;
    end

    assign strobe_n = !((cur.state == ST_PULSE) && en);

    // checker state: length of the current low run
    cnt_t run_len;
    always_ff @(posedge clk) begin
        if (rst)            run_len <= '0;
        else if (!strobe_n) run_len <= bump(run_len);
        else                run_len <= '0;
    end

    p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (rst)
        !en |-> strobe_n);

    p_no_overlong_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> (run_len < cnt_t'(WIDTH)));

    p_full_width_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(strobe_n) && en) |-> (run_len == cnt_t'(WIDTH)));

endmodule

// File: rtl/port_data_regs.sv
module port_data_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] port_out,
    output logic [DATA_W-1:0] cpu_rdata
);

    always_ff @(posedge clk) begin
        if (rst)         port_out <= '0;
        else if (cpu_wr) port_out <= cpu_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         cpu_rdata <= '0;
        else if (cpu_rd) cpu_rdata <= pin_in;
    end

    p_port_load_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_wr |=> (port_out == $past(cpu_wdata)));

    p_read_capture_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_rd |=> (cpu_rdata == $past(pin_in)));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> $stable(cpu_rdata));

endmodule

// File: rtl/port_strobe_gen.sv
module port_strobe_gen
    import strobe_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int WR_DELAY  = 2,
    parameter int RD_DELAY  = 3,
    parameter int STB_WIDTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_en,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] port_out,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              rd_n,
    output logic              wr_n
);

    localparam int N_DIR = 2;  // index 0 = write, 1 = read

    logic [N_DIR-1:0] dir_req;
    logic [N_DIR-1:0] dir_stb_n;

    assign dir_req = {cpu_rd, cpu_wr};

    port_data_regs #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst       (rst),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .pin_in    (pin_in),
        .port_out  (port_out),
        .cpu_rdata (cpu_rdata)
    );

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        localparam int DLY = (g == 0) ? WR_DELAY : RD_DELAY;
        strobe_channel #(.DELAY(DLY), .WIDTH(STB_WIDTH)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .en       (stb_en),
            .req      (dir_req[g]),
            .strobe_n (dir_stb_n[g])
        );
    end

    assign wr_n = dir_stb_n[0];
    assign rd_n = dir_stb_n[1];

    p_no_strobe_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        !stb_en |-> (rd_n && wr_n));

endmodule

// File: tb/port_strobe_gen_test.sv
`timescale 1ns/1ps
module port_strobe_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb_en = 1'b1;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] port_out, cpu_rdata;
    logic       rd_n, wr_n;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    port_strobe_gen uut (
        .clk(clk), .rst(rst), .stb_en(stb_en), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .pin_in(pin_in), .port_out(port_out),
        .cpu_rdata(cpu_rdata), .rd_n(rd_n), .wr_n(wr_n)
    );

    // per-cycle stimulus masks and expected low-strobe masks (bit i = cycle i)
    typedef struct packed {
        logic [15:0] rd;
        logic [15:0] wr;
        logic [15:0] en;
        logic [15:0] rd_lo;
        logic [15:0] wr_lo;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 16'h0001, 16'hFFFF, 16'h0000, 16'h0018},
        '{16'h0001, 16'h0000, 16'hFFFF, 16'h0030, 16'h0000},
        '{16'h0001, 16'h0001, 16'hFFFF, 16'h0030, 16'h0018},
        '{16'h0002, 16'h0001, 16'hFFFF, 16'h0060, 16'h0018},
        '{16'h0000, 16'h0003, 16'hFFFF, 16'h0000, 16'h0198},
        '{16'h0000, 16'h0007, 16'hFFFF, 16'h0000, 16'h0198},
        '{16'h0005, 16'h0000, 16'hFFFF, 16'h0630, 16'h0000},
        '{16'h0000, 16'h0011, 16'hFFFF, 16'h0000, 16'h0198},
        '{16'h0001, 16'h0001, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0000, 16'h0001, 16'hFFF7, 16'h0000, 16'h0008},
        '{16'h0000, 16'h0003, 16'hFFFB, 16'h0000, 16'h0000}
    };

    function automatic string tag_of(int idx);
        case (idx)
            0:       return "R3 single write";
            1:       return "R4 single read";
            2, 3:    return "R6 read and write together";
            4, 5:    return "R7 queued writes";
            6:       return "R7 queued reads";
            7:       return "R7 write at end edge";
            8:       return "R5 strobes disabled";
            default: return "R8 enable cancel";
        endcase
    endfunction

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_vec(input int idx);
        logic [15:0] rd_lo, wr_lo;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_lo[i] = ~rd_n;
            wr_lo[i] = ~wr_n;
            cpu_rd = VEC[idx].rd[i];
            cpu_wr = VEC[idx].wr[i];
            stb_en = VEC[idx].en[i];
        end
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0; stb_en = 1'b1;
        check({tag_of(idx), " rd_n trace"}, rd_lo, VEC[idx].rd_lo);
        check({tag_of(idx), " wr_n trace"}, wr_lo, VEC[idx].wr_lo);
        idle(8);
    endtask

    localparam logic [15:0] DVEC [4] = '{16'hA55A, 16'h00FF, 16'hFF00, 16'h3CC3};

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        check("R1 reset strobes", {14'd0, rd_n, wr_n}, 16'h0003);
        check("R1 reset port_out", {8'd0, port_out}, 16'h0000);
        rst = 1'b0;
        idle(2);

        for (int k = 0; k < NV; k++) run_vec(k);

        // R2 / R9 data path table
        for (int k = 0; k < 4; k++) begin
            cpu_wdata = DVEC[k][15:8];
            pin_in = DVEC[k][7:0];
            cpu_wr = 1'b1; cpu_rd = 1'b1;
            @(negedge clk);
            cpu_wr = 1'b0; cpu_rd = 1'b0;
            check("R2 port_out load", {8'd0, port_out}, {8'd0, DVEC[k][15:8]});
            check("R2 read capture", {8'd0, cpu_rdata}, {8'd0, DVEC[k][7:0]});
            pin_in = ~DVEC[k][7:0];
            idle(7);
            check("R9 rdata held past strobe", {8'd0, cpu_rdata}, {8'd0, DVEC[k][7:0]});
        end

        // R2: data loads with strobes disabled
        stb_en = 1'b0; cpu_wdata = 8'h66; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R2 load while disabled", {8'd0, port_out}, 16'h0066);
        idle(6);
        stb_en = 1'b1;

        // R8: enable drop forces strobe high within the same cycle
        cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        idle(2);
        check("R3 wr_n low before cancel", {15'd0, wr_n}, 16'h0000);
        stb_en = 1'b0;
        #1;
        check("R8 immediate force high", {15'd0, wr_n}, 16'h0001);
        @(negedge clk);
        stb_en = 1'b1;
        idle(6);

        // R1: reset mid-sequence clears queued work and the output register
        cpu_wdata = 8'h5A; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears port_out", {8'd0, port_out}, 16'h0000);
        begin
            logic seen_low;
            seen_low = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!wr_n) seen_low = 1'b1;
            end
            check("R1 reset discards sequences", {15'd0, seen_low}, 16'h0000);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule